// File: doc/BRIEF.md
# Redundant Channel Packet Distributor

This block sits on the transmit side of a processor module that is wired to four parallel, redundant interconnect channels. For every outgoing packet it draws a channel at random from the set currently reported healthy. It then steers the packet's words to that channel over a valid/ready handshake. The choice stays fixed from the first word until the word that carries the last flag is accepted, so a packet never straddles two channels.

The random draw comes from a 16-bit linear feedback shift register that advances every clock and can be reseeded. A draw is reduced to a position among the healthy channels, so a failed channel gets no new traffic and its share moves to the survivors without any software action. If no channel is healthy, the input is held off and a status flag is raised. Each channel keeps a count of the packets sent on it, which lets the spread be measured.

Top module: `lane_spreader`

## Requirements
- R1: After reset every packet counter reads zero and no channel valid is asserted while the input is idle.
- R2: At most one channel valid is asserted in any cycle, and a word offered on the input appears on exactly one channel when at least one channel is healthy.
- R3: Every word of a packet, including a first word stalled by a not-ready channel, goes to the channel chosen for that packet until the word with the last flag is accepted.
- R4: A new packet is only ever placed on a channel whose health bit is 1 in the cycle its first word is offered.
- R5: A channel whose health bit drops in mid-packet keeps carrying the current packet to its end; the following packet avoids it.
- R6: When all health bits are 0 and no packet is in progress, the input ready is 0, no channel valid is asserted and the all-fail flag is 1.
- R7: Input ready equals the ready of the selected channel, and the data and last flag reach that channel unchanged.
- R8: A channel's packet counter (16 bits, channel i at bits 16*i+15 down to 16*i) rises by exactly one in the cycle after the last word of a packet is accepted on it.
- R9: Over 400 single-word packets with all four channels healthy each channel receives between 70 and 130 packets; over 200 packets with only channels 0 and 2 healthy each of them receives between 70 and 130.
- R10: The random source is a 16-bit Galois shift register (mask 0xB400, shifting right) stepping every cycle; a seed load with a non-zero value replaces its state, a seed load of zero is ignored, so equal seeds and equal stimulus timing give equal channel sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Load the random source from seedValue |
| seedValue | input | 16 | New random source state (zero is ignored) |
| inData | input | DATA_W | Packet word |
| inValid | input | 1 | Packet word offered |
| inLast | input | 1 | Offered word ends the packet |
| inReady | output | 1 | Offered word is taken this cycle |
| chHealthy | input | NUM_CH | Per-channel availability |
| chReady | input | NUM_CH | Per-channel ready |
| chValid | output | NUM_CH | Per-channel valid |
| chData | output | NUM_CH*DATA_W | Per-channel word, channel i at slice i |
| chLast | output | NUM_CH | Per-channel last flag |
| allFail | output | 1 | No channel is healthy |
| pktCount | output | NUM_CH*CNT_W | Per-channel packet counter, channel i at slice i |

## Verification
The hardest situation to reach is a health change that lands between the first and last word of a packet, because it must fall after the channel is locked and before the release. The stimulus waits for the first word to be accepted, reads which channel carried it, clears exactly that channel's health bit, and then feeds the remaining words, checking that they stay on the same channel and that the next packet goes elsewhere. A stalled first word is reached by holding every channel ready low while the word is offered, so the random source keeps stepping while the lock must not move.

// File: rtl/lane_pkg.sv
package lane_pkg;
  // strobes from the control side to the datapath
  typedef struct packed {
    logic busy;     // a packet holds a locked channel
    logic capture;  // latch the fresh pick this cycle
    logic finish;   // last word accepted this cycle
  } laneStb_t;
endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     accept,
  input  logic     anyHealthy,
  output laneStb_t stb
);
  logic busyQ;

  always_comb begin
    stb.busy    = busyQ;
    stb.capture = !busyQ && inValid && anyHealthy;
    stb.finish  = accept && inLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (stb.finish) begin
      busyQ <= 1'b0;
    end else if (stb.capture) begin
      busyQ <= 1'b1;
    end
  end
endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4,
  parameter int LFSR_W = 16,
  parameter int CNT_W  = 16,
  parameter logic [LFSR_W-1:0] LFSR_MASK  = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_RESET = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     seedLoad,
  input  logic [LFSR_W-1:0]        seedValue,
  input  laneStb_t                 stb,
  input  logic [DATA_W-1:0]        inData,
  input  logic                     inValid,
  input  logic                     inLast,
  input  logic [NUM_CH-1:0]        chHealthy,
  input  logic [NUM_CH-1:0]        chReady,
  output logic                     inReady,
  output logic                     anyHealthy,
  output logic [NUM_CH-1:0]        chValid,
  output logic [NUM_CH*DATA_W-1:0] chData,
  output logic [NUM_CH-1:0]        chLast,
  output logic [NUM_CH*CNT_W-1:0]  pktCount
);
  localparam int PICK_W = 8;

  logic [LFSR_W-1:0] lfsrQ;
  logic [PICK_W-1:0] hCount;
  logic [PICK_W-1:0] slot;
  logic [PICK_W-1:0] seen;
  logic [NUM_CH-1:0] pickOh;
  logic [NUM_CH-1:0] lockQ;
  logic [NUM_CH-1:0] route;

  // random source: Galois, right shift
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= LFSR_RESET;
    end else if (seedLoad && (seedValue != '0)) begin
      lfsrQ <= seedValue;
    end else begin
      lfsrQ <= (lfsrQ >> 1) ^ (lfsrQ[0] ? LFSR_MASK : '0);
    end
  end

  // reduce the draw to the slot-th healthy channel
  always_comb begin
    hCount = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      hCount = hCount + PICK_W'(chHealthy[i]);
    end
    slot   = (hCount == '0) ? '0 : (lfsrQ[PICK_W-1:0] % hCount);
    seen   = '0;
    pickOh = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chHealthy[i]) begin
        if (seen == slot) pickOh[i] = 1'b1;
        seen = seen + PICK_W'(1);
      end
    end
  end

  assign anyHealthy = |chHealthy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ <= '0;
    end else if (stb.capture) begin
      lockQ <= pickOh;
    end
  end

  assign route   = stb.busy ? lockQ : pickOh;
  assign chValid = inValid ? route : '0;
  assign chLast  = inLast ? route : '0;
  assign inReady = |(chValid & chReady);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gLane
      logic [CNT_W-1:0] cntQ;
      assign chData[g*DATA_W +: DATA_W] = inData;
      assign pktCount[g*CNT_W +: CNT_W] = cntQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cntQ <= '0;
        end else if (stb.finish && route[g]) begin
          cntQ <= cntQ + CNT_W'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lane_spreader.sv
module lane_spreader
  import lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4,
  parameter int LFSR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     seedLoad,
  input  logic [LFSR_W-1:0]        seedValue,
  input  logic [DATA_W-1:0]        inData,
  input  logic                     inValid,
  input  logic                     inLast,
  output logic                     inReady,
  input  logic [NUM_CH-1:0]        chHealthy,
  input  logic [NUM_CH-1:0]        chReady,
  output logic [NUM_CH-1:0]        chValid,
  output logic [NUM_CH*DATA_W-1:0] chData,
  output logic [NUM_CH-1:0]        chLast,
  output logic                     allFail,
  output logic [NUM_CH*CNT_W-1:0]  pktCount
);
  laneStb_t ctrlStb;
  logic     anyHealthy;

  lane_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .accept(inReady), .anyHealthy(anyHealthy), .stb(ctrlStb)
  );

  lane_datapath #(
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .LFSR_W(LFSR_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedValue(seedValue),
    .stb(ctrlStb), .inData(inData), .inValid(inValid), .inLast(inLast),
    .chHealthy(chHealthy), .chReady(chReady), .inReady(inReady),
    .anyHealthy(anyHealthy), .chValid(chValid), .chData(chData),
    .chLast(chLast), .pktCount(pktCount)
  );

  assign allFail = !anyHealthy;
endmodule

// File: rtl/lane_spreader_chk.sv
module lane_spreader_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inReady,
  input logic                    inLast,
  input logic [NUM_CH-1:0]       chValid,
  input logic [NUM_CH-1:0]       chReady,
  input logic [NUM_CH-1:0]       chHealthy,
  input logic                    allFail,
  input logic [NUM_CH*CNT_W-1:0] pktCount,
  input logic                    busy
);
  // R2
  single_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chValid));

  // R3
  route_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|chValid) && !(inReady && inLast)) |=> (!inValid || chValid == $past(chValid)));

  // R4
  healthy_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (|chValid)) |-> (|(chValid & chHealthy)));

  // R6
  all_fail_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allFail && !busy) |-> (!inReady && chValid == '0));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gCnt
      // R8
      count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
        (chValid[g] && chReady[g] && inLast) |=>
          (pktCount[g*CNT_W +: CNT_W] == $past(pktCount[g*CNT_W +: CNT_W]) + CNT_W'(1)));
    end
  endgenerate
endmodule

bind lane_spreader lane_spreader_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inLast(inLast),
  .chValid(chValid), .chReady(chReady), .chHealthy(chHealthy), .allFail(allFail),
  .pktCount(pktCount), .busy(ctrlStb.busy)
);

// File: tb/test_lane_spreader.sv
module test_lane_spreader;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int NVEC   = 8;
  // {health mask, packet length}
  localparam logic [7:0] VECS [NVEC] = '{
    {4'b1111, 4'd1}, {4'b1111, 4'd3}, {4'b0110, 4'd2}, {4'b1000, 4'd4},
    {4'b0111, 4'd1}, {4'b1011, 4'd5}, {4'b0001, 4'd2}, {4'b1101, 4'd3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic seedLoad = 1'b0;
  logic [15:0] seedValue = '0;
  logic [DATA_W-1:0] inData = '0;
  logic inValid = 1'b0;
  logic inLast = 1'b0;
  logic inReady;
  logic [NUM_CH-1:0] chHealthy = 4'b1111;
  logic [NUM_CH-1:0] chReady = 4'b1111;
  logic [NUM_CH-1:0] chValid;
  logic [NUM_CH*DATA_W-1:0] chData;
  logic [NUM_CH-1:0] chLast;
  logic allFail;
  logic [NUM_CH*CNT_W-1:0] pktCount;

  int nChecks = 0;
  int nFail = 0;
  int expCnt [NUM_CH] = '{0, 0, 0, 0};
  int pktSeq = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_spreader i_lane_spreader (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedValue(seedValue),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .chHealthy(chHealthy), .chReady(chReady), .chValid(chValid), .chData(chData),
    .chLast(chLast), .allFail(allFail), .pktCount(pktCount)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ohIdx(input logic [NUM_CH-1:0] v);
    for (int i = NUM_CH - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  // sends one packet; drives at negedge, samples 1 time unit later
  task automatic sendPacket(input int len, input bit dropFirst, output int chIdx);
    int firstCh = -1;
    int cur;
    bit accepted;
    logic [NUM_CH-1:0] pickHealth = '0;
    for (int w = 0; w < len; w++) begin
      inValid = 1'b1;
      inData  = 32'hA000_0000 + DATA_W'(pktSeq * 16 + w);
      inLast  = (w == len - 1);
      accepted = 1'b0;
      while (!accepted) begin
        #1;
        cur = ohIdx(chValid);
        check($countones(chValid) == 1, "R2 single channel valid", $countones(chValid), 1);
        if (cur >= 0) begin
          check(chData[cur*DATA_W +: DATA_W] == inData, "R7 data passthrough",
                int'(chData[cur*DATA_W +: DATA_W]), int'(inData));
          check(chLast[cur] == inLast, "R7 last passthrough", chLast[cur], inLast);
          check(inReady == chReady[cur], "R7 ready follows channel", inReady, chReady[cur]);
        end
        if (firstCh < 0) begin
          firstCh = cur;
          pickHealth = chHealthy;
          check(cur >= 0 && pickHealth[cur], "R4 pick is healthy", cur, -1);
        end else begin
          check(cur == firstCh, "R3 R5 channel held", cur, firstCh);
        end
        accepted = inReady;
        @(negedge clk);
      end
      if (dropFirst && w == 0 && firstCh >= 0) chHealthy[firstCh] = 1'b0;
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    pktSeq++;
    chIdx = firstCh;
    if (firstCh >= 0) begin
      expCnt[firstCh]++;
      #1;
      check(int'(pktCount[firstCh*CNT_W +: CNT_W]) == expCnt[firstCh], "R8 packet count",
            int'(pktCount[firstCh*CNT_W +: CNT_W]), expCnt[firstCh]);
    end
  endtask

  task automatic runSeq(input logic [15:0] seed, input bit zeroAfter, output int seq [8]);
    @(negedge clk);
    seedLoad = 1'b1;
    seedValue = seed;
    @(negedge clk);
    seedLoad = zeroAfter;
    seedValue = '0;
    @(negedge clk);
    seedLoad = 1'b0;
    for (int k = 0; k < 8; k++) begin
      int c;
      sendPacket(1, 1'b0, c);
      seq[k] = c;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    int ch;
    int tally [NUM_CH];
    int seqA [8];
    int seqB [8];
    int seqC [8];
    bit same;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(pktCount == '0, "R1 counters zero", int'(pktCount[CNT_W-1:0]), 0);
    check(chValid == '0, "R1 no channel valid", int'(chValid), 0);
    check(allFail == 1'b0, "R1 R6 no all-fail with healthy set", allFail, 0);
    @(negedge clk);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      chHealthy = VECS[v][7:4];
      sendPacket(int'(VECS[v][3:0]), 1'b0, ch);
      check(ch >= 0 && VECS[v][4 + ch], "R4 table pick in mask", ch, -1);
    end
    chHealthy = 4'b1111;

    // R3: stalled first word keeps its channel
    chReady = 4'b0000;
    fork
      sendPacket(2, 1'b0, ch);
      begin
        repeat (3) begin
          #2;
          check(inReady == 1'b0, "R3 stalled word not taken", inReady, 0);
          @(negedge clk);
        end
        chReady = 4'b1111;
      end
    join

    // R5: health drop mid-packet
    begin
      int ch2;
      sendPacket(4, 1'b1, ch);
      check(ch >= 0 && chHealthy[ch] == 1'b0, "R5 dropped channel", ch, -1);
      sendPacket(1, 1'b0, ch2);
      check(ch2 != ch, "R5 next packet avoids dropped channel", ch2, ch);
    end
    chHealthy = 4'b1111;

    // R6: nothing healthy
    chHealthy = 4'b0000;
    inValid = 1'b1;
    inLast = 1'b1;
    repeat (3) begin
      #1;
      check(inReady == 1'b0, "R6 input held off", inReady, 0);
      check(chValid == '0, "R6 no channel valid", int'(chValid), 0);
      check(allFail == 1'b1, "R6 all-fail flag", allFail, 1);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast = 1'b0;
    chHealthy = 4'b0010;
    sendPacket(1, 1'b0, ch);
    check(ch == 1, "R6 R4 recovery on only healthy channel", ch, 1);
    chHealthy = 4'b1111;

    // R10: seeded sequences
    runSeq(16'h1234, 1'b0, seqA);
    runSeq(16'h1234, 1'b1, seqB);
    runSeq(16'h1234, 1'b0, seqC);
    same = 1'b1;
    for (int k = 0; k < 8; k++) if (seqA[k] != seqC[k]) same = 1'b0;
    check(same, "R10 equal seed repeats sequence", seqC[0], seqA[0]);
    same = 1'b1;
    for (int k = 0; k < 8; k++) if (seqA[k] != seqB[k]) same = 1'b0;
    check(same, "R10 zero seed ignored", seqB[0], seqA[0]);

    // R9: spread, all healthy
    tally = '{0, 0, 0, 0};
    for (int p = 0; p < 400; p++) begin
      sendPacket(1, 1'b0, ch);
      if (ch >= 0) tally[ch]++;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      check(tally[i] >= 70 && tally[i] <= 130, "R9 even spread four channels", tally[i], 100);
    end

    // R9: spread over channels 0 and 2
    chHealthy = 4'b0101;
    tally = '{0, 0, 0, 0};
    for (int p = 0; p < 200; p++) begin
      sendPacket(1, 1'b0, ch);
      if (ch >= 0) tally[ch]++;
    end
    check(tally[0] >= 70 && tally[0] <= 130, "R9 spread channel 0", tally[0], 100);
    check(tally[2] >= 70 && tally[2] <= 130, "R9 spread channel 2", tally[2], 100);
    check(tally[1] + tally[3] == 0, "R4 R9 failed channels unused", tally[1] + tally[3], 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule